// File: doc/BRIEF.md
# Packed Halfword Halving Subtract Unit

This execution unit takes a 32-bit operand pair that each hold two signed 16-bit fractional lanes. In each lane it subtracts the second operand from the first and halves the result, rounding if asked. The arithmetic is done at 17 bits, so a lane result never saturates and no overflow indication exists. The two lane results are packed as {upper, lower} and sign-extended to a 64-bit destination value.

The unit receives a raw 32-bit instruction word together with the two source register values. It decodes the word under one of two encoding formats, picked by a format-select input. A word that matches neither variant in the chosen format raises an illegal-instruction flag. A matching word with execution disabled raises a disabled flag. In both cases no result is produced. Results leave through one registered stage with a valid/ready handshake.

Top module: `phsub_halve_unit`

## Requirements
- R1: Without rounding, each lane result is bits 16..1 of the 17-bit difference {a[15],a} - {b[15],b}. Examples: 0x8000-0x7FFF gives 0x8000, 0x7FFF-0x8000 gives 0x7FFF, and 0x0000-0x0001 gives 0xFFFF.
- R2: With rounding, 1 is added to the 17-bit difference before bits 16..1 are taken, and no saturation is applied. Examples: 0x8000-0x7FFF gives 0x8001, 0x7FFF-0x8000 wraps to 0x8000, and 0x0000-0x0001 gives 0x0000.
- R3: The upper lane uses operand bits 31..16 and the lower lane uses bits 15..0. The result bits 31..0 are {upper, lower}, and bits 63..32 all copy bit 31.
- R4: When fmt_sel=0, the compact format is decoded: bits 31..26 = 000000, the destination index is in bits 15..11, and bits 10..0 are 01001001101 (no rounding) or 11001001101 (rounding).
- R5: When fmt_sel=1, the standard format is decoded: bits 31..26 = 011111, the destination index is in bits 15..11, bits 10..6 are 01001 (no rounding) or 01011 (rounding), and bits 5..0 are 011000.
- R6: An accepted word that matches no variant in the selected format sets out_illegal for one cycle, with out_valid low. A word that is valid only in the other format counts as such a word.
- R7: An accepted matching word with dsp_enable low sets out_disabled for one cycle, with out_valid low and out_illegal low.
- R8: An input is accepted on a rising edge where in_valid and in_ready are both high. Its result appears with out_valid high after that edge. With no new accept and out_ready high, out_valid drops after the following edge.
- R9: in_ready is low exactly while out_valid is high and out_ready is low. During that time out_value and out_dst hold, and no new input is taken.
- R10: After reset, out_valid, out_illegal and out_disabled are low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_sel | input | 1 | Encoding format: 0 compact, 1 standard |
| dsp_enable | input | 1 | Execution enable |
| in_valid | input | 1 | Input word and operands are offered |
| in_ready | output | 1 | Unit can take an input this cycle |
| instr | input | 32 | Raw instruction word |
| src_a | input | 32 | Minuend operand (two lanes) |
| src_b | input | 32 | Subtrahend operand (two lanes) |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_dst | output | 5 | Destination register index |
| out_value | output | 64 | Sign-extended packed result |
| out_illegal | output | 1 | Accepted word was not a recognised variant |
| out_disabled | output | 1 | Accepted word was refused because execution is disabled |

## Verification
The bench targets the lane extremes 0x8000-0x7FFF, 0x7FFF-0x8000 and 0x0000-0x0001 in both rounding modes. A unit that saturates would return 0x7FFF instead of the wrapped 0x8000. A unit that shifts before rounding, or that subtracts at 16 bits, would get the lowest bit or the sign wrong. It also checks that a word that is legal only in the other format is flagged illegal, that the sign extension follows the upper lane, and that the disabled case reports no result. A stalled result is held while a new input is offered, which exposes a unit that overwrites its output or drops the waiting instruction.

// File: rtl/phsub_halve_unit.sv
module phsub_halve_unit #(
  parameter int LANE_W = 16,
  parameter int LANES  = 2,
  parameter int IDX_W  = 5,
  parameter int XLEN   = 64
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      fmt_sel,
  input  logic                      dsp_enable,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [31:0]               instr,
  input  logic [LANE_W*LANES-1:0]   src_a,
  input  logic [LANE_W*LANES-1:0]   src_b,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [IDX_W-1:0]          out_dst,
  output logic [XLEN-1:0]           out_value,
  output logic                      out_illegal,
  output logic                      out_disabled
);
  localparam int PACK_W = LANE_W * LANES;
  localparam int DIFF_W = LANE_W + 1;

  logic cmp_plain, cmp_round, std_plain, std_round;
  logic hit, rnd, accept;
  logic [PACK_W-1:0] lane_res, res_q;
  logic [IDX_W-1:0]  dst_q;

  assign cmp_plain = (instr[31:26] == 6'b000000) && (instr[10:0] == 11'b01001001101);
  assign cmp_round = (instr[31:26] == 6'b000000) && (instr[10:0] == 11'b11001001101);
  assign std_plain = (instr[31:26] == 6'b011111) && (instr[10:6] == 5'b01001) && (instr[5:0] == 6'b011000);
  assign std_round = (instr[31:26] == 6'b011111) && (instr[10:6] == 5'b01011) && (instr[5:0] == 6'b011000);

  assign hit = fmt_sel ? (std_plain | std_round) : (cmp_plain | cmp_round);
  assign rnd = fmt_sel ? std_round : cmp_round;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [DIFF_W-1:0] diff;
    assign diff = {src_a[g*LANE_W+LANE_W-1], src_a[g*LANE_W +: LANE_W]}
                - {src_b[g*LANE_W+LANE_W-1], src_b[g*LANE_W +: LANE_W]}
                + DIFF_W'(rnd);
    assign lane_res[g*LANE_W +: LANE_W] = LANE_W'(diff >> 1);
  end

  assign in_ready = !(out_valid && !out_ready);
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_illegal  <= 1'b0;
      out_disabled <= 1'b0;
      res_q        <= '0;
      dst_q        <= '0;
    end else if (in_ready) begin
      out_valid    <= accept && hit && dsp_enable;
      out_illegal  <= accept && !hit;
      out_disabled <= accept && hit && !dsp_enable;
      if (accept) begin
        res_q <= lane_res;
        dst_q <= instr[15:11];
      end
    end
  end

  assign out_dst   = dst_q;
  assign out_value = {{(XLEN-PACK_W){res_q[PACK_W-1]}}, res_q};

  // R9
  hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_value) && $stable(out_dst)));

  // R6
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({out_valid, out_illegal, out_disabled}));

  // R8
  valid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid));

  // R6
  illegal_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_illegal |-> $past(in_valid));

  // R7
  disabled_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_disabled |-> ($past(in_valid) && !$past(dsp_enable)));
endmodule

// File: tb/phsub_halve_unit_tb.sv
module phsub_halve_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fmt_sel = 1'b0;
  logic        dsp_enable = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] instr = '0;
  logic [31:0] src_a = '0;
  logic [31:0] src_b = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [4:0]  out_dst;
  logic [63:0] out_value;
  logic        out_illegal;
  logic        out_disabled;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  phsub_halve_unit dut_i (
    .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .dsp_enable(dsp_enable),
    .in_valid(in_valid), .in_ready(in_ready), .instr(instr),
    .src_a(src_a), .src_b(src_b), .out_valid(out_valid), .out_ready(out_ready),
    .out_dst(out_dst), .out_value(out_value), .out_illegal(out_illegal),
    .out_disabled(out_disabled)
  );

  function automatic logic [31:0] enc_c(input logic [4:0] rt, input logic [4:0] rs,
                                        input logic [4:0] rd, input logic rnd);
    return {6'b000000, rt, rs, rd, (rnd ? 11'b11001001101 : 11'b01001001101)};
  endfunction

  function automatic logic [31:0] enc_s(input logic [4:0] rs, input logic [4:0] rt,
                                        input logic [4:0] rd, input logic rnd);
    return {6'b011111, rs, rt, rd, (rnd ? 5'b01011 : 5'b01001), 6'b011000};
  endfunction

  function automatic logic [15:0] ref_lane(input logic [15:0] a, input logic [15:0] b,
                                           input logic rnd);
    logic [16:0] d;
    d = {a[15], a} - {b[15], b} + {16'b0, rnd};
    return d[16:1];
  endfunction

  function automatic logic [63:0] ref_val(input logic [31:0] a, input logic [31:0] b,
                                          input logic rnd);
    logic [31:0] p;
    p = {ref_lane(a[31:16], b[31:16], rnd), ref_lane(a[15:0], b[15:0], rnd)};
    return {{32{p[31]}}, p};
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic fmt, input logic en, input logic [31:0] w,
                        input logic [31:0] a, input logic [31:0] b);
    fmt_sel = fmt; dsp_enable = en; instr = w; src_a = a; src_b = b;
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk(out_valid == 1'b0, "R10 out_valid", 64'(out_valid), 64'd0);
    chk(out_illegal == 1'b0 && out_disabled == 1'b0, "R10 flags",
        64'({out_illegal, out_disabled}), 64'd0);
    chk(in_ready == 1'b1, "R10 in_ready", 64'(in_ready), 64'd1);
  endtask

  task automatic t_corner_plain;
    run_op(1'b0, 1'b1, enc_c(5'd2, 5'd1, 5'd3, 1'b0), {16'h8000, 16'h0000}, {16'h7FFF, 16'h0001});
    chk(out_valid && out_value == 64'hFFFFFFFF_8000FFFF, "R1 8000-7FFF|0000-0001",
        out_value, 64'hFFFFFFFF_8000FFFF);
    run_op(1'b0, 1'b1, enc_c(5'd2, 5'd1, 5'd3, 1'b0), {16'h7FFF, 16'h7FFF}, {16'h8000, 16'h8000});
    chk(out_valid && out_value == 64'h00000000_7FFF7FFF, "R1 7FFF-8000",
        out_value, 64'h00000000_7FFF7FFF);
  endtask

  task automatic t_corner_round;
    run_op(1'b0, 1'b1, enc_c(5'd2, 5'd1, 5'd4, 1'b1), {16'h8000, 16'h0000}, {16'h7FFF, 16'h0001});
    chk(out_valid && out_value == 64'hFFFFFFFF_80010000, "R2 8000-7FFF|0000-0001",
        out_value, 64'hFFFFFFFF_80010000);
    run_op(1'b1, 1'b1, enc_s(5'd1, 5'd2, 5'd4, 1'b1), {16'h0000, 16'h7FFF}, {16'h0001, 16'h8000});
    chk(out_valid && out_value == 64'h00000000_00008000, "R2 7FFF-8000 wrap",
        out_value, 64'h00000000_00008000);
  endtask

  task automatic t_formats;
    logic [31:0] a, b;
    a = 32'h1234_F00D;
    b = 32'h0F0F_A5A5;
    for (int i = 0; i < 8; i++) begin
      logic rnd;
      logic [4:0] rd;
      rnd = i[0];
      rd = 5'(i * 7 + 3);
      run_op(1'b0, 1'b1, enc_c(5'd9, 5'd17, rd, rnd), a, b);
      chk(out_valid && out_dst == rd && out_value == ref_val(a, b, rnd), "R4 compact",
          out_value, ref_val(a, b, rnd));
      run_op(1'b1, 1'b1, enc_s(5'd17, 5'd9, rd, rnd), a, b);
      chk(out_valid && out_dst == rd && out_value == ref_val(a, b, rnd), "R5 standard",
          out_value, ref_val(a, b, rnd));
      a = a * 32'd1103515245 + 32'd12345;
      b = b * 32'd22695477 + 32'd1;
    end
    run_op(1'b0, 1'b1, enc_c(5'd0, 5'd0, 5'd1, 1'b0), {16'h0002, 16'h8000}, {16'h0000, 16'h0000});
    chk(out_value[63:32] == 32'h0 && out_value[31:0] == 32'h0001C000, "R3 lane order/sext+",
        out_value, 64'h00000000_0001C000);
    run_op(1'b0, 1'b1, enc_c(5'd0, 5'd0, 5'd1, 1'b0), {16'h8000, 16'h0002}, {16'h0000, 16'h0000});
    chk(out_value == 64'hFFFFFFFF_C0000001, "R3 lane order/sext-",
        out_value, 64'hFFFFFFFF_C0000001);
  endtask

  task automatic t_illegal;
    run_op(1'b1, 1'b1, enc_c(5'd1, 5'd2, 5'd3, 1'b0), 32'h1, 32'h2);
    chk(out_illegal && !out_valid && !out_disabled, "R6 compact word in std fmt",
        64'({out_valid, out_illegal, out_disabled}), 64'b010);
    run_op(1'b0, 1'b1, enc_s(5'd1, 5'd2, 5'd3, 1'b1), 32'h1, 32'h2);
    chk(out_illegal && !out_valid, "R6 std word in compact fmt",
        64'({out_valid, out_illegal}), 64'b01);
    run_op(1'b1, 1'b1, enc_s(5'd1, 5'd2, 5'd3, 1'b0) ^ 32'h0000_0001, 32'h1, 32'h2);
    chk(out_illegal && !out_valid, "R6 bad function field",
        64'({out_valid, out_illegal}), 64'b01);
    @(posedge clk); @(negedge clk);
    chk(!out_illegal, "R6 flag one cycle", 64'(out_illegal), 64'd0);
  endtask

  task automatic t_disabled;
    run_op(1'b0, 1'b0, enc_c(5'd1, 5'd2, 5'd3, 1'b1), 32'h5555, 32'h1111);
    chk(out_disabled && !out_valid && !out_illegal, "R7 disabled",
        64'({out_valid, out_illegal, out_disabled}), 64'b001);
    run_op(1'b0, 1'b0, 32'hFFFF_FFFF, 32'h5555, 32'h1111);
    chk(out_illegal && !out_disabled, "R7 illegal wins when disabled",
        64'({out_illegal, out_disabled}), 64'b10);
  endtask

  task automatic t_latency;
    @(posedge clk); @(negedge clk);
    chk(!out_valid, "R8 idle before", 64'(out_valid), 64'd0);
    run_op(1'b1, 1'b1, enc_s(5'd4, 5'd5, 5'd31, 1'b0), 32'h0004_0006, 32'h0002_0002);
    chk(out_valid && out_value == 64'h00000000_00010002 && out_dst == 5'd31, "R8 one-cycle result",
        out_value, 64'h00000000_00010002);
    @(posedge clk); @(negedge clk);
    chk(!out_valid, "R8 valid drops", 64'(out_valid), 64'd0);
  endtask

  task automatic t_stall;
    logic [63:0] first, second;
    first  = ref_val(32'h4000_0100, 32'h1000_0300, 1'b0);
    second = ref_val(32'h0010_0020, 32'h0030_0040, 1'b1);
    out_ready = 1'b0;
    run_op(1'b0, 1'b1, enc_c(5'd1, 5'd2, 5'd7, 1'b0), 32'h4000_0100, 32'h1000_0300);
    chk(out_valid && !in_ready && out_value == first, "R9 stalled result",
        out_value, first);
    fmt_sel = 1'b0; dsp_enable = 1'b1; instr = enc_c(5'd1, 5'd2, 5'd9, 1'b1);
    src_a = 32'h0010_0020; src_b = 32'h0030_0040; in_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    chk(out_valid && !in_ready && out_value == first && out_dst == 5'd7, "R9 hold while offered",
        out_value, first);
    out_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid && out_value == second && out_dst == 5'd9, "R9 next taken after drain",
        out_value, second);
    @(posedge clk); @(negedge clk);
    chk(!out_valid, "R9 single acceptance", 64'(out_valid), 64'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_corner_plain;
    t_corner_round;
    t_formats;
    t_illegal;
    t_disabled;
    t_latency;
    t_stall;
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule